// File: doc/BRIEF.md
# Two-Road Sensor-Driven Signal Controller

This block sequences the lights at the crossing of two roads, A and B. Each road has a traffic sensor that is high while vehicles are waiting or passing. A road keeps its green light for as long as its own sensor reports traffic. When that sensor drops, the road shows yellow for exactly one clock, and then the other road gets green. The second road follows the same rule.

The controller is a Moore machine with four phases. The lamp outputs are decoded from the phase register alone, and the phase changes only on a rising clock edge. The clock is expected to be slow, so one period equals the whole yellow interval. Reset is synchronous and active low. It puts road A on green and road B on red.

Top module: `xroad_signal_ctrl`

## Requirements
- R1: A clock edge with `rst_n` low leaves `lamp_a` = 2'b00 (green) and `lamp_b` = 2'b10 (red) after that edge. Lamp code: green 2'b00, yellow 2'b01, red 2'b10.
- R2: While A is green and B is red, an edge with `sense_a` high keeps A green and B red.
- R3: While A is green, an edge with `sense_a` low makes A yellow (2'b01) and leaves B red.
- R4: From A yellow, the next edge gives A red and B green, whatever the sensor values are.
- R5: While B is green and A is red, an edge with `sense_b` high keeps B green and A red.
- R6: While B is green, an edge with `sense_b` low makes B yellow (2'b01) and leaves A red.
- R7: From B yellow, the next edge gives A green and B red, whatever the sensor values are.
- R8: `sense_b` has no effect while A is green, and `sense_a` has no effect while B is green.
- R9: In every cycle at least one lamp output is red, and neither output is ever 2'b11.
- R10: The lamp outputs do not change between rising edges, even when the sensors change inside a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock; one period is the yellow interval |
| rst_n | input | 1 | Synchronous reset, active low |
| sense_a | input | 1 | High while road A has traffic |
| sense_b | input | 1 | High while road B has traffic |
| lamp_a | output | 2 | Road A light: 00 green, 01 yellow, 10 red |
| lamp_b | output | 2 | Road B light: 00 green, 01 yellow, 10 red |

## Verification
The only register is the phase register, so every lamp result is due one edge after the sensors and reset that were sampled at that edge. The bench changes its inputs just after a falling edge. A behavioural model advances at each rising edge, using the same input values that the design samples there. The outputs are compared on the following falling edge, half a period after they can change. Inside each cycle the sensors are toggled once more and the lamps are compared again. This shows that no sensor value reaches the outputs before the next edge.

// File: rtl/xroad_pkg.sv
// Shared types for the two-road signal controller.
// Assumes a 2-bit phase code and a 2-bit lamp code, as fixed in the brief.
package xroad_pkg;

    localparam int PHASE_W = 2;
    localparam int LAMP_W  = 2;
    localparam int N_ROADS = 2;

    // The controller's phases. The codes are fixed because bit 1 tells which road owns the crossing.
    typedef enum logic [PHASE_W-1:0] {
        PH_A_GO   = 2'b00,
        PH_A_WARN = 2'b01,
        PH_B_GO   = 2'b10,
        PH_B_WARN = 2'b11
    } phase_t;

    // The code driven on a lamp output. 2'b11 is never produced.
    typedef enum logic [LAMP_W-1:0] {
        LAMP_GO   = 2'b00,
        LAMP_WARN = 2'b01,
        LAMP_STOP = 2'b10
    } lamp_t;

endpackage

// File: rtl/xroad_next.sv
// Next-phase logic. A green phase holds while its own road's sensor is high.
// A yellow phase always moves on.
// Assumes the sensors are already synchronous to clk.
module xroad_next
    import xroad_pkg::*;
(
    input  phase_t cur,
    input  logic   sense_a,
    input  logic   sense_b,
    output phase_t nxt
);

    // Choose the following phase from the current phase and the owning road's sensor.
    always_comb begin
        nxt = cur;
        unique case (cur)
            PH_A_GO:   nxt = sense_a ? PH_A_GO : PH_A_WARN;
            PH_A_WARN: nxt = PH_B_GO;
            PH_B_GO:   nxt = sense_b ? PH_B_GO : PH_B_WARN;
            PH_B_WARN: nxt = PH_A_GO;
            default:   nxt = PH_A_GO;
        endcase
    end

endmodule

// File: rtl/xroad_phase_reg.sv
// Phase register with a synchronous, active-low reset to A green.
// Assumes a single clock domain.
module xroad_phase_reg
    import xroad_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  phase_t nxt,
    output phase_t cur
);

    // Load the next phase on each rising edge, or the A-green phase while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) cur <= PH_A_GO;
        else        cur <= nxt;
    end

endmodule

// File: rtl/xroad_road_lamp.sv
// Decodes one road's lamp from the phase alone (Moore output).
// OWNER_BIT is the value of phase bit 1 while this road owns the crossing.
// Assumes the phase codes defined in xroad_pkg.
module xroad_road_lamp
    import xroad_pkg::*;
#(
    parameter logic OWNER_BIT = 1'b0
) (
    input  phase_t              cur,
    output logic [LAMP_W-1:0]   lamp
);

    // Owner phases give green or yellow; any other phase gives red.
    always_comb begin
        if (cur[1] != OWNER_BIT) lamp = LAMP_STOP;
        else if (cur[0])         lamp = LAMP_WARN;
        else                     lamp = LAMP_GO;
    end

endmodule

// File: rtl/xroad_signal_ctrl.sv
// Top level of the two-road controller. It chains the next-phase logic, the phase register
// and one lamp decoder per road.
// Assumes a slow clock whose period is the yellow interval.
module xroad_signal_ctrl
    import xroad_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sense_a,
    input  logic        sense_b,
    output logic [1:0]  lamp_a,
    output logic [1:0]  lamp_b
);

    phase_t cur_ph;
    phase_t nxt_ph;
    logic [LAMP_W-1:0] lamps [N_ROADS];

    xroad_next u_next (
        .cur     (cur_ph),
        .sense_a (sense_a),
        .sense_b (sense_b),
        .nxt     (nxt_ph)
    );

    xroad_phase_reg u_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .nxt   (nxt_ph),
        .cur   (cur_ph)
    );

    // One decoder per road. Road index r owns the crossing when phase bit 1 equals r.
    for (genvar r = 0; r < N_ROADS; r++) begin : g_road
        xroad_road_lamp #(.OWNER_BIT(1'(r))) u_lamp (
            .cur  (cur_ph),
            .lamp (lamps[r])
        );
    end

    assign lamp_a = lamps[0];
    assign lamp_b = lamps[1];

endmodule

// File: rtl/xroad_signal_chk.sv
// Checker for the lamp sequence, bound to the top. It observes only the top's ports.
// Assumes the lamp code green 00, yellow 01, red 10.
module xroad_signal_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sense_a,
    input logic       sense_b,
    input logic [1:0] lamp_a,
    input logic [1:0] lamp_b
);

    AST_A_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_a == 2'b00 && sense_a) |=> (lamp_a == 2'b00 && lamp_b == 2'b10)); // R2
    AST_A_TO_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_a == 2'b00 && !sense_a) |=> (lamp_a == 2'b01 && lamp_b == 2'b10)); // R3
    AST_A_WARN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_a == 2'b01) |=> (lamp_a == 2'b10 && lamp_b == 2'b00)); // R4
    AST_B_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_b == 2'b00 && sense_b) |=> (lamp_b == 2'b00 && lamp_a == 2'b10)); // R5
    AST_B_TO_WARN: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_b == 2'b00 && !sense_b) |=> (lamp_b == 2'b01 && lamp_a == 2'b10)); // R6
    AST_B_WARN_END: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_b == 2'b01) |=> (lamp_a == 2'b00 && lamp_b == 2'b10)); // R7
    AST_ONE_RED: assert property (@(posedge clk) disable iff (!rst_n)
        (lamp_a == 2'b10 || lamp_b == 2'b10) && lamp_a != 2'b11 && lamp_b != 2'b11); // R9

endmodule

bind xroad_signal_ctrl xroad_signal_chk u_chk (.*);

// File: tb/xroad_signal_ctrl_test.sv
// Self-checking bench with a behavioural reference model that is compared on every clock.
module xroad_signal_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 50000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sense_a = 1'b0;
    logic       sense_b = 1'b0;
    logic [1:0] lamp_a;
    logic [1:0] lamp_b;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    m_step = 0;       // model: 0 A green, 1 A yellow, 2 B green, 3 B yellow
    string m_tag = "R1";

    xroad_signal_ctrl uut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // The model's lamp values for its current step.
    function automatic logic [1:0] exp_a();
        return (m_step == 0) ? 2'b00 : (m_step == 1) ? 2'b01 : 2'b10;
    endfunction
    function automatic logic [1:0] exp_b();
        return (m_step == 2) ? 2'b00 : (m_step == 3) ? 2'b01 : 2'b10;
    endfunction

    // Advance the model at a rising edge and record which requirement the step exercises.
    task automatic model_edge();
        if (!rst_n) begin
            m_step = 0; m_tag = "R1";
        end else begin
            case (m_step)
                0: begin
                    m_tag = !sense_a ? "R3" : (sense_b ? "R8" : "R2");
                    if (!sense_a) m_step = 1;
                end
                1: begin m_tag = "R4"; m_step = 2; end
                2: begin
                    m_tag = !sense_b ? "R6" : (sense_a ? "R8" : "R5");
                    if (!sense_b) m_step = 3;
                end
                default: begin m_tag = "R7"; m_step = 0; end
            endcase
        end
    endtask

    // Compare both lamps with the model, then check that at least one road shows red.
    task automatic compare(input string tag);
        checks++;
        if (lamp_a !== exp_a() || lamp_b !== exp_b()) begin
            errors++;
            $display("FAIL %s: lamp_a=%b lamp_b=%b expected lamp_a=%b lamp_b=%b",
                     tag, lamp_a, lamp_b, exp_a(), exp_b());
        end
        checks++;
        if (!(lamp_a === 2'b10 || lamp_b === 2'b10)) begin
            errors++;
            $display("FAIL R9: lamp_a=%b lamp_b=%b expected at least one 10", lamp_a, lamp_b);
        end
    endtask

    // Run one cycle: drive the inputs, let the edge pass, then compare.
    // When glitch is set, the sensors flip inside the cycle and the lamps must not follow (R10).
    task automatic cycle(input logic sa, input logic sb, input logic rn, input bit glitch);
        if (glitch) begin
            sense_a = ~sa; sense_b = ~sb;
            #(CLK_PERIOD/4);
            compare("R10");
        end
        sense_a = sa; sense_b = sb; rst_n = rn;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        compare(m_tag);
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        cycle(1'b1, 1'b1, 1'b0, 0);                  // R1 reset state
        cycle(1'b1, 1'b1, 1'b0, 0);
        for (int i = 0; i < 4; i++) cycle(1'b1, i[0], 1'b1, 0);   // R2, R8 with sense_b toggling
        cycle(1'b0, 1'b1, 1'b1, 0);                  // R3
        cycle(1'b1, 1'b0, 1'b1, 0);                  // R4, sensors ignored
        for (int i = 0; i < 4; i++) cycle(i[0], 1'b1, 1'b1, 0);   // R5, R8 with sense_a toggling
        cycle(1'b1, 1'b0, 1'b1, 0);                  // R6
        cycle(1'b0, 1'b1, 1'b1, 0);                  // R7, sensors ignored
        cycle(1'b0, 1'b0, 1'b1, 0);                  // leave A green at once
        cycle(1'b0, 1'b0, 1'b1, 0);
        cycle(1'b1, 1'b1, 1'b1, 0);                  // B green held
        cycle(1'b1, 1'b1, 1'b0, 0);                  // R1 reset taken from B green
        for (int i = 0; i < 400; i++) begin
            logic sa, sb;
            sa = ($urandom_range(0, 3) != 0);
            sb = ($urandom_range(0, 3) != 0);
            cycle(sa, sb, ($urandom_range(0, 99) != 0), 1);
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule